// File: doc/BRIEF.md
# Automatic Modem-Line Flow Control

This block handles hardware flow control for a single serial channel so that software does not have to. On the transmit side it watches an active-low permission input from the far end. Once that input has passed through a synchronizer and is seen deasserted, the block holds off the start of the next character. A character that is already being shifted out runs to its end, because only new starts are gated. On the receive side it compares the receive FIFO fill level with a programmable trigger ladder. It drives an active-low request output with hysteresis, and it raises a trigger interrupt when the fill level reaches the selected level.

A single line-select bit picks which input pair takes part in flow control. The first pair is the clear-to-send input and the request-to-send output. The second pair is the data-set-ready input and the data-terminal-ready output. The output that is not selected always works as a plain general-purpose pin driven by its own manual bit. Automatic request control only has an effect when the manual bit of the selected output has already asserted that output. The FIFO and the serial shifter sit outside this block. The block only sees the FIFO level and the shifter's request and busy signals.

Top module: `uart_auto_flow`

## Requirements
- R1: When transmit gating is enabled, `tx_hold` is 1 while the synchronized selected input is high and 0 while it is low. When gating is disabled, `tx_hold` is 0.
- R2: `tx_start` equals `tx_req & ~tx_busy & ~tx_hold`. A character in progress (`tx_busy`=1) is never cut short, and no new start is issued during it.
- R3: With `sel_dsr`=0 the block monitors `cts_n` and drives `rts_n`. With `sel_dsr`=1 it monitors `dsr_n` and drives `dtr_n`. The enables and `sel_dsr` act through flops, one clock after they are sampled.
- R4: `rx_trig_irq` is 1 in the cycle after an edge at which `rx_level` was at least the selected trigger level, and 0 otherwise.
- R5: With automatic request control active, the selected output goes high one edge after `rx_level` reaches the ladder step above the trigger. It returns low one edge after `rx_level` falls below the ladder step beneath the trigger. Between those two points it keeps its previous value.
- R6: For a FIFO depth of 16, `trig_sel` codes 0, 1, 2 and 3 select trigger levels 1, 4, 8 and 14. The step above code 3 is 16. The step below code 0 is 0, and for code 0 the output returns low when the FIFO is empty.
- R7: While the manual bit of the selected output is 0, that output is high whatever the automatic state, and the hysteresis state is cleared.
- R8: While automatic request control is disabled, the selected output equals the inverse of its manual bit. The unselected output always equals the inverse of its own manual bit.
- R9: Reset clears both automatic enables and the interrupt. During reset `tx_hold`=0, `rx_trig_irq`=0 and `rts_n`=`~rts_bit`.
- R10: A change on the monitored input reaches `tx_hold` after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_cts_en | input | 1 | Enable automatic transmit gating |
| auto_rts_en | input | 1 | Enable automatic request output control |
| sel_dsr | input | 1 | 0: CTS/RTS pair, 1: DSR/DTR pair |
| rts_bit | input | 1 | Manual RTS control, 1 asserts (drives low) |
| dtr_bit | input | 1 | Manual DTR control, 1 asserts (drives low) |
| trig_sel | input | 2 | Receive trigger ladder code |
| rx_level | input | $clog2(FIFO_DEPTH+1) | Receive FIFO fill level |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| tx_req | input | 1 | Transmitter has a character ready |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_start | output | 1 | Permission to start the next character |
| tx_hold | output | 1 | Transmission held by flow control |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rx_trig_irq | output | 1 | Receive trigger interrupt |

## Verification
The assertions assume that `rx_level` never goes above the FIFO depth. They also assume that the enables and `sel_dsr` are configuration values that may change on any cycle but are only trusted after they have been held for the number of cycles each property states in its antecedent. The stimulus walks `rx_level` up and down in small clamped steps between 0 and 16, so every fill level is reached and it never jumps past the depth. It changes the configuration inputs only rarely, so long stretches stay stable and the properties' conditions are actually met. The pins and the transmitter handshake inputs are toggled at random.

// File: rtl/fc_pkg.sv
package fc_pkg;

   // Ladder step i (i = -1 .. 4). Step -1 is the empty floor, 0..3 are the
   // selectable trigger levels, 4 is the full ceiling.
   function automatic int unsigned fc_step(input int unsigned depth, input int idx);
      int unsigned v;
      case (idx)
         -1:      v = 0;
         0:       v = 1;
         1:       v = depth / 4;
         2:       v = depth / 2;
         3:       v = depth - 2;
         default: v = depth;
      endcase
      return v;
   endfunction

   localparam int unsigned FC_LADDER_LEN = 6;

endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   initial begin
      if (STAGES < 2) $fatal(1, "fc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate (
   input  logic hold_en,
   input  logic flow_in_n,
   input  logic tx_req,
   input  logic tx_busy,
   output logic tx_hold,
   output logic tx_start
);

   // Only the start of a new character is gated; a busy shifter is untouched.
   assign tx_hold  = hold_en & flow_in_n;
   assign tx_start = tx_req & ~tx_busy & ~tx_hold;

endmodule

// File: rtl/fc_rx_flow.sv
module fc_rx_flow
   import fc_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 16,
   localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auto_en,
   input  logic             manual_on,
   input  logic [1:0]       trig_sel,
   input  logic [LVL_W-1:0] rx_level,
   output logic             flow_out_n,
   output logic             trig_irq
);

   // Ladder table, entry k holds step k-1.
   logic [LVL_W-1:0] ladder [FC_LADDER_LEN];

   for (genvar k = 0; k < FC_LADDER_LEN; k++) begin : g_ladder
      assign ladder[k] = LVL_W'(fc_step(FIFO_DEPTH, k - 1));
   end

   logic [2:0]       idx_trig;
   logic [LVL_W-1:0] lvl_trig, lvl_up, lvl_dn;

   always_comb begin
      idx_trig = {1'b0, trig_sel} + 3'd1;
      lvl_trig = ladder[idx_trig];
      lvl_up   = ladder[idx_trig + 3'd1];
      lvl_dn   = ladder[idx_trig - 3'd1];
   end

   logic halted;
   logic live;
   logic go_halt, go_resume;

   assign live      = auto_en & manual_on;
   assign go_halt   = (rx_level >= lvl_up);
   assign go_resume = (rx_level < lvl_dn) || (rx_level == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         halted <= 1'b0;
      else if (!live)     halted <= 1'b0;
      else if (go_halt)   halted <= 1'b1;
      else if (go_resume) halted <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_irq <= 1'b0;
      else        trig_irq <= (rx_level >= lvl_trig);
   end

   assign flow_out_n = auto_en ? (~manual_on | halted) : ~manual_on;

endmodule

// File: rtl/uart_auto_flow.sv
module uart_auto_flow #(
   parameter int unsigned FIFO_DEPTH  = 16,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auto_cts_en,
   input  logic             auto_rts_en,
   input  logic             sel_dsr,
   input  logic             rts_bit,
   input  logic             dtr_bit,
   input  logic [1:0]       trig_sel,
   input  logic [LVL_W-1:0] rx_level,
   input  logic             cts_n,
   input  logic             dsr_n,
   input  logic             tx_req,
   input  logic             tx_busy,
   output logic             tx_start,
   output logic             tx_hold,
   output logic             rts_n,
   output logic             dtr_n,
   output logic             rx_trig_irq
);

   initial begin
      if (FIFO_DEPTH < 8) $fatal(1, "uart_auto_flow: FIFO_DEPTH must be at least 8");
   end

   localparam int unsigned NPINS = 2;

   // Configuration flops, cleared by reset so both automatic modes start off.
   logic cts_en_q, rts_en_q, sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cts_en_q <= 1'b0;
         rts_en_q <= 1'b0;
         sel_q    <= 1'b0;
      end else begin
         cts_en_q <= auto_cts_en;
         rts_en_q <= auto_rts_en;
         sel_q    <= sel_dsr;
      end
   end

   // Both inputs are synchronized so that switching the select never
   // exposes an unsynchronized pin.
   logic [NPINS-1:0] pin_raw, pin_sync;
   assign pin_raw = {dsr_n, cts_n};

   for (genvar p = 0; p < NPINS; p++) begin : g_sync
      fc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (pin_raw[p]),
         .q     (pin_sync[p])
      );
   end

   logic flow_in_n;
   assign flow_in_n = sel_q ? pin_sync[1] : pin_sync[0];

   fc_tx_gate u_tx (
      .hold_en   (cts_en_q),
      .flow_in_n (flow_in_n),
      .tx_req    (tx_req),
      .tx_busy   (tx_busy),
      .tx_hold   (tx_hold),
      .tx_start  (tx_start)
   );

   logic manual_on, flow_out_n;
   assign manual_on = sel_q ? dtr_bit : rts_bit;

   fc_rx_flow #(.FIFO_DEPTH(FIFO_DEPTH)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .auto_en    (rts_en_q),
      .manual_on  (manual_on),
      .trig_sel   (trig_sel),
      .rx_level   (rx_level),
      .flow_out_n (flow_out_n),
      .trig_irq   (rx_trig_irq)
   );

   assign rts_n = sel_q ? ~rts_bit : flow_out_n;
   assign dtr_n = sel_q ? flow_out_n : ~dtr_bit;

endmodule

// File: rtl/uart_auto_flow_chk.sv
module uart_auto_flow_chk
   import fc_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 16,
   localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             auto_cts_en,
   input logic             auto_rts_en,
   input logic             sel_dsr,
   input logic             rts_bit,
   input logic [1:0]       trig_sel,
   input logic [LVL_W-1:0] rx_level,
   input logic             cts_n,
   input logic             tx_busy,
   input logic             tx_start,
   input logic             tx_hold,
   input logic             rts_n,
   input logic             rx_trig_irq
);

   logic [1:0] since;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          since <= 2'd0;
      else if (since != 3) since <= since + 2'd1;
   end

   function automatic int unsigned up_of(input logic [1:0] ts);
      return fc_step(FIFO_DEPTH, int'(ts) + 1);
   endfunction

   function automatic int unsigned trig_of(input logic [1:0] ts);
      return fc_step(FIFO_DEPTH, int'(ts));
   endfunction

   // R1 / R10: hold follows the pin as it was two edges back
   a_r10_cts_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
      (since == 3 && $past(auto_cts_en) && !$past(sel_dsr)) |-> (tx_hold == $past(cts_n, 2)));

   // R2: busy shifter never sees a new start
   a_r2_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |-> !tx_start);

   // R4: interrupt follows last edge's level comparison
   a_r4_trig_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (since != 0) |-> (rx_trig_irq == (int'($past(rx_level)) >= int'(trig_of($past(trig_sel))))));

   // R5: reaching the upper step deasserts the request
   a_r5_upper_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (since == 3 && $past(auto_rts_en, 2) && $past(auto_rts_en) &&
       !$past(sel_dsr, 2) && !$past(sel_dsr) && $past(rts_bit) && rts_bit &&
       int'($past(rx_level)) >= int'(up_of($past(trig_sel)))) |-> rts_n);

   // R7: manual bit low forces the output high
   a_r7_manual_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (since != 0 && !$past(sel_dsr) && !rts_bit) |-> rts_n);

   // R8: auto off or unselected means plain manual output
   a_r8_plain_output: assert property (@(posedge clk) disable iff (!rst_n)
      (since != 0 && ($past(sel_dsr) || !$past(auto_rts_en))) |-> (rts_n == !rts_bit));

endmodule

bind uart_auto_flow uart_auto_flow_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .auto_cts_en (auto_cts_en),
   .auto_rts_en (auto_rts_en),
   .sel_dsr     (sel_dsr),
   .rts_bit     (rts_bit),
   .trig_sel    (trig_sel),
   .rx_level    (rx_level),
   .cts_n       (cts_n),
   .tx_busy     (tx_busy),
   .tx_start    (tx_start),
   .tx_hold     (tx_hold),
   .rts_n       (rts_n),
   .rx_trig_irq (rx_trig_irq)
);

// File: tb/uart_auto_flow_test.sv
`timescale 1ns/1ps
module uart_auto_flow_test;

   localparam int DEPTH = 16;
   localparam int LW    = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic auto_cts_en = 0, auto_rts_en = 0, sel_dsr = 0, rts_bit = 1, dtr_bit = 0;
   logic [1:0] trig_sel = 0;
   logic [LW-1:0] rx_level = 0;
   logic cts_n = 1, dsr_n = 1, tx_req = 0, tx_busy = 0;
   logic tx_start, tx_hold, rts_n, dtr_n, rx_trig_irq;

   int checks = 0, fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   uart_auto_flow #(.FIFO_DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en),
      .sel_dsr(sel_dsr), .rts_bit(rts_bit), .dtr_bit(dtr_bit), .trig_sel(trig_sel),
      .rx_level(rx_level), .cts_n(cts_n), .dsr_n(dsr_n), .tx_req(tx_req), .tx_busy(tx_busy),
      .tx_start(tx_start), .tx_hold(tx_hold), .rts_n(rts_n), .dtr_n(dtr_n),
      .rx_trig_irq(rx_trig_irq)
   );

   // Ladder from R6
   function automatic int step(input int i);
      case (i)
         -1: return 0;
         0:  return 1;
         1:  return 4;
         2:  return 8;
         3:  return 14;
         default: return 16;
      endcase
   endfunction

   // Reference state built from the requirements
   logic m_cen, m_ren, m_sel, m_c1, m_c2, m_d1, m_d2, m_halt, m_irq;

   function automatic logic man_sel();
      return m_sel ? dtr_bit : rts_bit;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cen <= 0; m_ren <= 0; m_sel <= 0;
         m_c1 <= 1; m_c2 <= 1; m_d1 <= 1; m_d2 <= 1;
         m_halt <= 0; m_irq <= 0;
      end else begin
         m_cen <= auto_cts_en; m_ren <= auto_rts_en; m_sel <= sel_dsr;
         m_c1 <= cts_n; m_c2 <= m_c1; m_d1 <= dsr_n; m_d2 <= m_d1;
         m_irq <= (int'(rx_level) >= step(int'(trig_sel)));
         if (!(m_ren && man_sel())) m_halt <= 0;
         else if (int'(rx_level) >= step(int'(trig_sel) + 1)) m_halt <= 1;
         else if (int'(rx_level) < step(int'(trig_sel) - 1) || rx_level == 0) m_halt <= 0;
      end
   end

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic check_all(input string rtag);
      logic fin, hold, auto_n, e_rts, e_dtr;
      fin    = m_sel ? m_d2 : m_c2;
      hold   = m_cen & fin;
      auto_n = m_ren ? (~man_sel() | m_halt) : ~man_sel();
      e_rts  = m_sel ? ~rts_bit : auto_n;
      e_dtr  = m_sel ? auto_n : ~dtr_bit;
      chk("R1", "tx_hold", tx_hold, hold);
      chk("R2", "tx_start", tx_start, tx_req & ~tx_busy & ~hold);
      chk("R4", "rx_trig_irq", rx_trig_irq, m_irq);
      chk(rtag, "rts_n", rts_n, e_rts);
      chk(rtag, "dtr_n", dtr_n, e_dtr);
   endtask

   task automatic cyc(input string rtag);
      @(negedge clk);
      check_all(rtag);
   endtask

   task automatic set_level(input int lv, input string rtag);
      rx_level = LW'(lv);
      cyc(rtag);
   endtask

   initial begin
      void'($urandom(32'h5EED_0F1C));
      // R9: reset state
      repeat (3) @(negedge clk);
      chk("R9", "tx_hold in reset", tx_hold, 0);
      chk("R9", "irq in reset", rx_trig_irq, 0);
      chk("R9", "rts_n in reset", rts_n, 0);
      rst_n = 1;
      cyc("R9");

      // R8: auto off, plain outputs
      rts_bit = 0; dtr_bit = 1; cyc("R8");
      chk("R8", "rts_n manual", rts_n, 1);
      chk("R8", "dtr_n manual", dtr_n, 0);
      rts_bit = 1; cyc("R8");

      // R10: synchronizer latency
      auto_cts_en = 1; cts_n = 0; tx_req = 1;
      repeat (4) cyc("R1");
      cts_n = 1;
      cyc("R10");
      chk("R10", "hold after one edge", tx_hold, 0);
      cyc("R10");
      chk("R10", "hold after two edges", tx_hold, 1);
      chk("R2", "start blocked", tx_start, 0);
      cts_n = 0; repeat (2) cyc("R10");
      chk("R1", "resume", tx_hold, 0);
      tx_busy = 1; cyc("R2");
      chk("R2", "busy no start", tx_start, 0);
      tx_busy = 0;

      // R6/R5: ladder code 3, ceiling 16
      auto_rts_en = 1; trig_sel = 3; rts_bit = 1;
      set_level(0, "R5");
      set_level(13, "R4");
      chk("R4", "irq below 14", rx_trig_irq, 0);
      set_level(14, "R4");
      set_level(15, "R6");
      chk("R4", "irq at 14", rx_trig_irq, 1);
      chk("R6", "rts_n at 14 (below ceiling)", rts_n, 0);
      set_level(16, "R6");
      cyc("R6");
      chk("R6", "rts_n at 16", rts_n, 1);
      set_level(9, "R5");
      cyc("R5");
      chk("R5", "rts_n held in band", rts_n, 1);
      set_level(7, "R5");
      cyc("R5");
      chk("R5", "rts_n below lower step", rts_n, 0);

      // R6: code 0, upper 4, floor empty
      trig_sel = 0;
      set_level(4, "R6"); cyc("R6");
      chk("R6", "code0 halt at 4", rts_n, 1);
      set_level(1, "R6"); cyc("R6");
      chk("R6", "code0 held at 1", rts_n, 1);
      set_level(0, "R6"); cyc("R6");
      chk("R6", "code0 resume at empty", rts_n, 0);

      // R7: manual bit low overrides
      set_level(12, "R7"); cyc("R7");
      rts_bit = 0; cyc("R7");
      chk("R7", "manual low forces high", rts_n, 1);
      rts_bit = 1; set_level(2, "R7"); cyc("R7");
      chk("R7", "state cleared", rts_n, 0);

      // R3: alternate pair
      sel_dsr = 1; dtr_bit = 1; rts_bit = 0; dsr_n = 1; cts_n = 0;
      repeat (3) cyc("R3");
      chk("R3", "dsr holds", tx_hold, 1);
      chk("R3", "rts plain", rts_n, 1);
      set_level(16, "R3"); cyc("R3");
      chk("R3", "dtr halted", dtr_n, 1);
      dsr_n = 0; repeat (2) cyc("R3");
      chk("R3", "dsr released", tx_hold, 0);

      // Random phase
      for (int i = 0; i < 6000; i++) begin
         int lv;
         if ($urandom_range(0, 99) < 2) auto_cts_en = ~auto_cts_en;
         if ($urandom_range(0, 99) < 2) auto_rts_en = ~auto_rts_en;
         if ($urandom_range(0, 199) < 1) sel_dsr = ~sel_dsr;
         if ($urandom_range(0, 99) < 3) rts_bit = ~rts_bit;
         if ($urandom_range(0, 99) < 3) dtr_bit = ~dtr_bit;
         if ($urandom_range(0, 99) < 2) trig_sel = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 99) < 10) cts_n = ~cts_n;
         if ($urandom_range(0, 99) < 10) dsr_n = ~dsr_n;
         tx_req = 1'($urandom_range(0, 1));
         tx_busy = 1'($urandom_range(0, 1));
         lv = int'(rx_level) + $urandom_range(0, 6) - 3;
         if (lv < 0) lv = 0;
         if (lv > DEPTH) lv = DEPTH;
         rx_level = LW'(lv);
         cyc("R5");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(150000 * 10);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule